// File: doc/BRIEF.md
# Pipeline Stall and Squash Control

This block decides, every cycle, whether a five-stage in-order pipeline advances, freezes its front end, or discards wrong-path work. The pipeline has no operand forwarding, so a register value is only safe to read once the instruction that produces it has left the pipeline. The block compares the source register indices of the instruction sitting in decode with the destination indices of the three older instructions in execute, memory and write-back. A match against any stage whose register-write enable is set freezes fetch and decode and sends an empty slot into execute. The frozen instruction retries on the following cycle.

Branches and jumps are resolved in execute. When one resolves taken, the two younger instructions behind it are on the wrong path. The block loads the redirect target into the program counter and turns both of those instructions into no-ops. A taken redirect overrides a data stall in the same cycle, because the stalled instruction is itself one of the discarded ones. All outputs are combinational functions of the current inputs. The enables and clears feed the pipeline registers directly.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A nonzero decode source index equal to the execute-stage destination, with the execute write enable set and no taken branch, gives pc_en=0, ifid_en=0, ifid_clr=0, idex_bubble=1, pc_redirect=0.
- R2: The same match against the memory-stage destination, with its write enable set, gives the same stall outputs as R1.
- R3: The same match against the write-back-stage destination, with its write enable set, gives the same stall outputs as R1.
- R4: Either decode source can raise the stall. Source 0 occupies dec_src[REG_W-1:0] and source 1 occupies the next REG_W bits. This holds for every index up to the highest, 31 by default.
- R5: Register index 0 never causes a stall, even when an older stage targets index 0 with its write enable set.
- R6: A matching destination whose stage write enable is clear has no effect. The outputs stay at the normal-advance values of R7.
- R7: With no hazard and no taken branch, the outputs are pc_en=1, pc_redirect=0, ifid_en=1, ifid_clr=0, idex_bubble=0.
- R8: With ex_taken=1, the outputs are pc_en=1, pc_redirect=1, ifid_en=1, ifid_clr=1, idex_bubble=1. The fetched and decoded younger instructions both become no-ops.
- R9: When ex_taken=1 and a data hazard are present in the same cycle, the squash outputs of R8 are produced, not the stall outputs.
- R10: The outputs settle in the same cycle as the inputs change, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_src | input | N_SRC*REG_W | Source register indices of the decode instruction, source 0 in the low bits |
| ex_rd | input | REG_W | Destination index of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| mem_rd | input | REG_W | Destination index of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_W | Destination index of the write-back-stage instruction |
| wb_we | input | 1 | Write-back-stage instruction writes a register |
| ex_taken | input | 1 | Branch or jump in execute resolved taken |
| pc_en | output | 1 | Program counter may update |
| pc_redirect | output | 1 | Program counter loads the resolved target |
| ifid_en | output | 1 | Fetch/decode register may capture |
| ifid_clr | output | 1 | Fetch/decode register loads a no-op |
| idex_bubble | output | 1 | Decode/execute register receives a no-op |

## Verification
The bench builds the block at its defaults: five-bit register indices and two decode sources compared against three older stages. At this width it can reach both ends of the index range, register 0 and register 31, in each source slot. It can also place the same index in all three older stages at once and combine that with a taken branch. This covers every way a match can be suppressed: index zero, a clear write enable, and squash priority.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Older pipeline stages compared against decode: execute, memory, write-back
  localparam int OLDER_STAGES = 3;

  typedef struct packed {
    logic pc_en;
    logic pc_redirect;
    logic ifid_en;
    logic ifid_clr;
    logic idex_bubble;
  } hz_ctrl_t;

  localparam hz_ctrl_t CTRL_RUN    = '{pc_en: 1'b1, pc_redirect: 1'b0, ifid_en: 1'b1,
                                       ifid_clr: 1'b0, idex_bubble: 1'b0};
  localparam hz_ctrl_t CTRL_STALL  = '{pc_en: 1'b0, pc_redirect: 1'b0, ifid_en: 1'b0,
                                       ifid_clr: 1'b0, idex_bubble: 1'b1};
  localparam hz_ctrl_t CTRL_SQUASH = '{pc_en: 1'b1, pc_redirect: 1'b1, ifid_en: 1'b1,
                                       ifid_clr: 1'b1, idex_bubble: 1'b1};
endpackage

// File: rtl/src_match.sv
module src_match #(
  parameter int REG_W = 5,
  parameter int N_OLD = 3
) (
  input  logic [REG_W-1:0]       src,
  input  logic [N_OLD*REG_W-1:0] old_rd,
  input  logic [N_OLD-1:0]       old_we,
  output logic                   hit
);
  logic [N_OLD-1:0] stage_hit;
  logic             src_live;

  // One comparator per older stage, qualified by that stage's write enable
  for (genvar g = 0; g < N_OLD; g++) begin : g_stage
    assign stage_hit[g] = old_we[g] && (old_rd[g*REG_W +: REG_W] == src);
  end

  // Register zero is hard-wired and never produces a dependence
  assign src_live = (src != '0);
  assign hit      = src_live && (|stage_hit);

  always_comb begin
    // R5
    if (src == '0) begin
      zero_src_no_hit_chk: assert (!hit) else $error("index zero raised a hit");
    end
  end
endmodule

// File: rtl/stall_detect.sv
module stall_detect #(
  parameter int REG_W = 5,
  parameter int N_SRC = 2,
  parameter int N_OLD = 3
) (
  input  logic [N_SRC*REG_W-1:0] srcs,
  input  logic [N_OLD*REG_W-1:0] old_rd,
  input  logic [N_OLD-1:0]       old_we,
  output logic                   stall
);
  logic [N_SRC-1:0] src_hit;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    src_match #(.REG_W(REG_W), .N_OLD(N_OLD)) u_match (
      .src    (srcs[s*REG_W +: REG_W]),
      .old_rd (old_rd),
      .old_we (old_we),
      .hit    (src_hit[s])
    );
  end

  assign stall = |src_hit;

  always_comb begin
    // R6
    if (old_we == '0) begin
      no_writer_no_stall_chk: assert (!stall) else $error("stall without any writer");
    end
  end
endmodule

// File: rtl/squash_arb.sv
module squash_arb
  import hzd_pkg::*;
(
  input  logic     stall,
  input  logic     taken,
  output hz_ctrl_t ctrl
);
  // Taken redirect outranks the data stall: the stalled instruction is wrong-path
  always_comb begin
    if (taken) begin
      ctrl = CTRL_SQUASH;
    end else if (stall) begin
      ctrl = CTRL_STALL;
    end else begin
      ctrl = CTRL_RUN;
    end
  end

  always_comb begin
    // R9
    if (taken) begin
      squash_wins_chk: assert (ctrl.pc_redirect && ctrl.ifid_clr && ctrl.idex_bubble && ctrl.pc_en)
        else $error("taken branch did not squash");
    end
    // R1
    if (stall && !taken) begin
      stall_freeze_chk: assert (!ctrl.pc_en && !ctrl.ifid_en && ctrl.idex_bubble && !ctrl.ifid_clr)
        else $error("stall did not freeze front end");
    end
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int N_SRC = 2
) (
  input  logic [N_SRC*REG_W-1:0] dec_src,
  input  logic [REG_W-1:0]       ex_rd,
  input  logic                   ex_we,
  input  logic [REG_W-1:0]       mem_rd,
  input  logic                   mem_we,
  input  logic [REG_W-1:0]       wb_rd,
  input  logic                   wb_we,
  input  logic                   ex_taken,
  output logic                   pc_en,
  output logic                   pc_redirect,
  output logic                   ifid_en,
  output logic                   ifid_clr,
  output logic                   idex_bubble
);
  localparam int N_OLD = OLDER_STAGES;

  logic [N_OLD*REG_W-1:0] old_rd;
  logic [N_OLD-1:0]       old_we;
  logic                   data_stall;
  hz_ctrl_t               ctrl;

  // Stage order: index 0 execute, 1 memory, 2 write-back
  assign old_rd = {wb_rd, mem_rd, ex_rd};
  assign old_we = {wb_we, mem_we, ex_we};

  stall_detect #(.REG_W(REG_W), .N_SRC(N_SRC), .N_OLD(N_OLD)) u_detect (
    .srcs   (dec_src),
    .old_rd (old_rd),
    .old_we (old_we),
    .stall  (data_stall)
  );

  squash_arb u_arb (
    .stall (data_stall),
    .taken (ex_taken),
    .ctrl  (ctrl)
  );

  assign pc_en       = ctrl.pc_en;
  assign pc_redirect = ctrl.pc_redirect;
  assign ifid_en     = ctrl.ifid_en;
  assign ifid_clr    = ctrl.ifid_clr;
  assign idex_bubble = ctrl.idex_bubble;

  always_comb begin
    // R7
    if (!data_stall && !ex_taken) begin
      run_idle_chk: assert (pc_en && ifid_en && !idex_bubble && !ifid_clr && !pc_redirect)
        else $error("pipeline held without cause");
    end
    // R8
    if (ifid_clr) begin
      clr_implies_bubble_chk: assert (idex_bubble && pc_redirect) else $error("partial squash");
    end
  end
endmodule

// File: tb/pipe_hazard_ctrl_test.sv
`timescale 1ns/100ps
module pipe_hazard_ctrl_test;
  localparam int REG_W = 5;
  localparam int N_SRC = 2;
  localparam int VW    = 43;
  localparam int NV    = 12;

  localparam logic [4:0] O_RUN = 5'b10100;
  localparam logic [4:0] O_STL = 5'b00001;
  localparam logic [4:0] O_SQ  = 5'b11111;

  // fields: rs0 rs1 exrd exwe memrd memwe wbrd wbwe taken expect req
  localparam logic [VW-1:0] VEC [NV] = '{
    {5'd3,  5'd4,  5'd3,  1'b1, 5'd0,  1'b0, 5'd0, 1'b0, 1'b0, O_STL, 9'd1},  // R1
    {5'd7,  5'd2,  5'd0,  1'b0, 5'd7,  1'b1, 5'd0, 1'b0, 1'b0, O_STL, 9'd2},  // R2
    {5'd9,  5'd1,  5'd0,  1'b0, 5'd0,  1'b0, 5'd9, 1'b1, 1'b0, O_STL, 9'd3},  // R3
    {5'd1,  5'd31, 5'd0,  1'b0, 5'd31, 1'b1, 5'd0, 1'b0, 1'b0, O_STL, 9'd4},  // R4
    {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0, 1'b1, 1'b0, O_RUN, 9'd5},  // R5
    {5'd0,  5'd6,  5'd0,  1'b1, 5'd0,  1'b0, 5'd0, 1'b0, 1'b0, O_RUN, 9'd5},  // R5
    {5'd5,  5'd6,  5'd5,  1'b0, 5'd6,  1'b0, 5'd5, 1'b0, 1'b0, O_RUN, 9'd6},  // R6
    {5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 5'd5, 1'b1, 1'b0, O_RUN, 9'd7},  // R7
    {5'd1,  5'd2,  5'd0,  1'b0, 5'd0,  1'b0, 5'd0, 1'b0, 1'b1, O_SQ,  9'd8},  // R8
    {5'd3,  5'd3,  5'd3,  1'b1, 5'd3,  1'b1, 5'd3, 1'b1, 1'b1, O_SQ,  9'd9},  // R9
    {5'd31, 5'd0,  5'd31, 1'b1, 5'd0,  1'b0, 5'd0, 1'b0, 1'b0, O_STL, 9'd4},  // R4
    {5'd8,  5'd8,  5'd0,  1'b0, 5'd0,  1'b0, 5'd8, 1'b1, 1'b1, O_SQ,  9'd9}   // R9
  };

  logic clk, rst_n;
  logic [N_SRC*REG_W-1:0] dec_src;
  logic [REG_W-1:0] ex_rd, mem_rd, wb_rd;
  logic ex_we, mem_we, wb_we, ex_taken;
  logic pc_en, pc_redirect, ifid_en, ifid_clr, idex_bubble;
  int tests, fails;
  bit done;

  pipe_hazard_ctrl #(.REG_W(REG_W), .N_SRC(N_SRC)) uut (
    .dec_src(dec_src), .ex_rd(ex_rd), .ex_we(ex_we), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .ex_taken(ex_taken), .pc_en(pc_en),
    .pc_redirect(pc_redirect), .ifid_en(ifid_en), .ifid_clr(ifid_clr),
    .idex_bubble(idex_bubble)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [4:0] outs();
    return {pc_en, pc_redirect, ifid_en, ifid_clr, idex_bubble};
  endfunction

  task automatic check(input string req, input logic [4:0] exp);
    tests++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s: outputs=%b expected=%b", req, outs(), exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] v);
    dec_src  = {v[37:33], v[42:38]};
    ex_rd    = v[32:28]; ex_we  = v[27];
    mem_rd   = v[26:22]; mem_we = v[21];
    wb_rd    = v[20:16]; wb_we  = v[15];
    ex_taken = v[14];
  endtask

  initial begin
    tests = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    dec_src = '0; ex_rd = '0; mem_rd = '0; wb_rd = '0;
    ex_we = 0; mem_we = 0; wb_we = 0; ex_taken = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R7 reset", O_RUN);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1 check($sformatf("R%0d vec%0d", VEC[i][8:0], i), VEC[i][13:9]);
    end

    // R10: change in mid-cycle, observe before next edge
    @(negedge clk);
    drive(VEC[7]);
    #0.5 check("R10 settle run", O_RUN);
    ex_rd = 5'd2;
    #0.5 check("R10 settle stall", O_STL);
    ex_taken = 1'b1;
    #0.5 check("R10 settle squash", O_SQ);

    // R4: second source alone, low source zero
    @(negedge clk);
    drive('0);
    dec_src = {5'd17, 5'd0}; mem_rd = 5'd17; mem_we = 1'b1;
    #1 check("R4 source1 only", O_STL);

    // R6 then R2: enable toggles the effect of the same match
    mem_we = 1'b0;
    #1 check("R6 enable clear", O_RUN);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: outputs=%b expected=completion", outs());
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule